// File: doc/BRIEF.md
# Byte FIFO Handshake Bridge

This block sits between a synchronous core and an external byte-wide USB FIFO device that runs on its own timing. The FIFO reports two active-low flags. One says it holds a received byte. The other says it has room for a byte to send. The bridge turns these flags into two core-side valid/ready streams, one for bytes arriving from the host and one for bytes going to it. It runs the strobe sequences the FIFO expects and owns the tri-state control of the shared 8-bit bus. The bus pins are split into an input value, an output value and an output enable, which the pad ring joins.

Both flags are first passed through synchronizer stages. A single state machine then serves one transfer at a time.

- `ST_IDLE` waits for a request.
  - It goes to `ST_RD_LOW` when a read is granted.
  - It goes to `ST_WR_SETUP` when a write is granted.
- `ST_RD_LOW` holds the read strobe low for a programmable number of clocks. It captures the bus on its last clock, then moves to `ST_RD_END`.
- `ST_RD_END` drives the read strobe high again, then moves to `ST_SETTLE`.
- `ST_WR_SETUP` raises the write strobe and drives the bus. It then moves to `ST_WR_HOLD`.
- `ST_WR_HOLD` drops the write strobe while the bus stays driven. It then moves to `ST_SETTLE`.
- `ST_SETTLE` waits out the synchronizer latency so that a stale flag is never taken for a new byte or new space. It then returns to `ST_IDLE`.

When a read and a write are both eligible in the same idle cycle, the grant alternates between the two directions.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While reset is held, the read strobe is high, the write strobe is low, the bus output enable is low, `rx_valid` is low and `tx_ready` is low, even if both FIFO flags are low and `tx_valid` is high.
- R2: A read begins (read strobe falls) only while the receive flag (low = byte present) is low and the core-side receive register is empty (`rx_valid` low). While `rx_valid` waits unaccepted, further bytes in the FIFO are left untouched.
- R3: The read strobe stays low for at least two consecutive clocks. The byte on the bus in the last low clock is captured and shown on `rx_data` with `rx_valid` high. Both stay unchanged until the clock in which `rx_ready` is high.
- R4: A write begins (write strobe rises) only while the transmit flag (low = space present) is low. The core byte is taken in the cycle where `tx_valid` and `tx_ready` are both high.
- R5: The write strobe is high for one clock with the bus driven, then falls while the bus stays driven with the same byte. The byte presented at the fall is the accepted core byte.
- R6: The bus output enable is high only while the write strobe is high or in the clock right after it falls. Otherwise the bus is left high-impedance.
- R7: The read strobe being low and the bus output enable being high never occur in the same clock.
- R8: When a read and a write are both eligible in the same idle clock, the direction not served last is granted. After reset, a write wins the first tie.
- R9: Bytes reach the core in the order the FIFO presents them, and reach the FIFO in the order the core gives them, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_rx_avail_n | input | 1 | FIFO flag, low while a received byte is waiting (asynchronous) |
| fifo_tx_space_n | input | 1 | FIFO flag, low while a byte can be accepted (asynchronous) |
| fifo_rd_n | output | 1 | Read strobe to the FIFO, active low |
| fifo_wr | output | 1 | Write strobe to the FIFO, byte latched on its falling edge |
| fifo_bus_in | input | 8 | Value seen on the shared data bus |
| fifo_bus_out | output | 8 | Value driven onto the shared data bus |
| fifo_bus_oe | output | 1 | Output enable for the shared data bus |
| rx_data | output | 8 | Byte received from the FIFO |
| rx_valid | output | 1 | `rx_data` holds an unaccepted byte |
| rx_ready | input | 1 | Core accepts `rx_data` |
| tx_data | input | 8 | Byte the core wants sent |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Bridge takes `tx_data` this clock |

## Verification
A pending read and a pending write can both be eligible in the same idle clock, and the arbitration between them is the delicate point.

To provoke this, a directed phase keeps both FIFO flags low apart from one-clock gaps after each transfer, holds `rx_ready` high and keeps `tx_valid` asserted. As a result, every idle clock carries both requests. The bench judges each strobe start by requiring that it differ in direction from the previous one.

A seeded random phase then mixes gaps, back-pressure and idle sources. In that phase the bench checks every strobe edge, the bus ownership and the byte order against bench-side byte generators.

// File: rtl/ufb_pkg.sv
package ufb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LOW,
        ST_RD_END,
        ST_WR_SETUP,
        ST_WR_HOLD,
        ST_SETTLE
    } ufb_state_e;

endpackage

// File: rtl/ufb_flag_sync.sv
module ufb_flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= async_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= 1'b1;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_n = chain[STAGES-1];

endmodule

// File: rtl/ufb_rr_pick.sv
module ufb_rr_pick (
    input  logic rd_req,
    input  logic wr_req,
    input  logic last_wr,
    output logic grant_rd,
    output logic grant_wr
);

    always_comb begin
        grant_wr = wr_req && (!rd_req || !last_wr);
        grant_rd = rd_req && (!wr_req || last_wr);
    end

endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge
    import ufb_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int RD_LOW_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_rx_avail_n,
    input  logic              fifo_tx_space_n,
    output logic              fifo_rd_n,
    output logic              fifo_wr,
    input  logic [DATA_W-1:0] fifo_bus_in,
    output logic [DATA_W-1:0] fifo_bus_out,
    output logic              fifo_bus_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);

    localparam int SETTLE_CYCLES = SYNC_STAGES + 1;
    localparam int MAX_COUNT     = (RD_LOW_CYCLES > SETTLE_CYCLES) ? RD_LOW_CYCLES : SETTLE_CYCLES;
    localparam int CNT_W         = (MAX_COUNT > 1) ? $clog2(MAX_COUNT) : 1;
    localparam logic [CNT_W-1:0] RD_LAST     = CNT_W'(RD_LOW_CYCLES - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

    ufb_state_e        state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [DATA_W-1:0] rx_q, tx_q;
    logic              rx_v, last_wr;
    logic              rx_flag_s, tx_flag_s;
    logic              rd_req, wr_req, grant_rd, grant_wr;
    logic              capture;

    ufb_flag_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .async_n(fifo_rx_avail_n), .sync_n(rx_flag_s)
    );

    ufb_flag_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
        .clk(clk), .rst_n(rst_n), .async_n(fifo_tx_space_n), .sync_n(tx_flag_s)
    );

    assign rd_req = (state == ST_IDLE) && !rx_flag_s && !rx_v;
    assign wr_req = (state == ST_IDLE) && !tx_flag_s && tx_valid;

    ufb_rr_pick u_pick (
        .rd_req(rd_req), .wr_req(wr_req), .last_wr(last_wr),
        .grant_rd(grant_rd), .grant_wr(grant_wr)
    );

    assign capture = (state == ST_RD_LOW) && (cnt == RD_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = '0;
        unique case (state)
            ST_IDLE: begin
                if (grant_wr)      state_nx = ST_WR_SETUP;
                else if (grant_rd) state_nx = ST_RD_LOW;
            end
            ST_RD_LOW: begin
                if (cnt == RD_LAST) state_nx = ST_RD_END;
                else                cnt_nx   = cnt + 1'b1;
            end
            ST_RD_END:   state_nx = ST_SETTLE;
            ST_WR_SETUP: state_nx = ST_WR_HOLD;
            ST_WR_HOLD:  state_nx = ST_SETTLE;
            ST_SETTLE: begin
                if (cnt == SETTLE_LAST) state_nx = ST_IDLE;
                else                    cnt_nx   = cnt + 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q    <= '0;
            rx_v    <= 1'b0;
            tx_q    <= '0;
            last_wr <= 1'b0;
        end else begin
            if (rx_v && rx_ready) rx_v <= 1'b0;
            if (capture) begin
                rx_q <= fifo_bus_in;
                rx_v <= 1'b1;
            end
            if (grant_wr) begin
                tx_q    <= tx_data;
                last_wr <= 1'b1;
            end else if (grant_rd) begin
                last_wr <= 1'b0;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        fifo_rd_n    = (state != ST_RD_LOW);
        fifo_wr      = (state == ST_WR_SETUP);
        fifo_bus_oe  = (state == ST_WR_SETUP) || (state == ST_WR_HOLD);
        fifo_bus_out = tx_q;
        rx_data      = rx_q;
        rx_valid     = rx_v;
        tx_ready     = grant_wr;
    end

    // R2: read starts only on a present byte and an empty holding register
    assert_rd_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_rd_n) |-> $past(!rx_flag_s && !rx_valid));

    // R3: read strobe low for at least two clocks
    assert_rd_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_rd_n) |-> !$past(fifo_rd_n, 2));

    // R3: an unaccepted byte holds
    assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R4: write starts only with space and a valid core byte
    assert_wr_start_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_wr) |-> $past(!tx_flag_s && tx_valid));

    // R5: data driven before and after the strobe falls
    assert_wr_data_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_wr) |-> (fifo_bus_oe && $past(fifo_bus_oe) && $stable(fifo_bus_out)));

    // R6: bus driven only around a write strobe
    assert_bus_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_bus_oe |-> (fifo_wr || $past(fifo_wr)));

    // R7: no read strobe while driving the bus
    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fifo_rd_n && fifo_bus_oe));

    // R8: tie goes to the direction not served last
    assert_tie_to_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req && !last_wr) |=> fifo_wr);
    assert_tie_to_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req && last_wr) |=> !fifo_rd_n);

endmodule

// File: tb/usb_fifo_bridge_tb.sv
module usb_fifo_bridge_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;
    localparam int NBYTES     = 300;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_avail_n, tx_space_n;
    logic [7:0] bus_in, tx_data;
    logic       rx_ready, tx_valid;
    wire        rd_n, wr, oe, rx_valid, tx_ready;
    wire  [7:0] bus_out, rx_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_fifo_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .fifo_rx_avail_n(rx_avail_n), .fifo_tx_space_n(tx_space_n),
        .fifo_rd_n(rd_n), .fifo_wr(wr),
        .fifo_bus_in(bus_in), .fifo_bus_out(bus_out), .fifo_bus_oe(oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    int checks = 0, failures = 0, cyc = 0;
    bit timeout = 0;
    int src_ptr = 0, src_total = NBYTES, rx_gap = 0;
    int snk_cnt = 0, tx_gap = 0;
    int core_rx = 0, core_tx = 0;
    int rd_run = 0, last_op = 0, gap_max = 1;
    int rx_pct = 100, tx_pct = 100;
    bit rr_mode = 0, prev_rd_n = 1, prev_wr = 0, rx_pend = 0;
    logic [7:0] pend_data = 8'h00;

    function automatic logic [7:0] exp_rx(int i);
        int v;
        v = i * 29 + 7;
        return 8'(v ^ (v >> 3));
    endfunction

    function automatic logic [7:0] exp_tx(int i);
        int v;
        v = i * 53 + 101;
        return 8'(v ^ 8'h5a);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > WD_LIMIT) timeout = 1;
        if (rx_gap > 0) rx_gap--;
        if (tx_gap > 0) tx_gap--;
        if (rx_pend) begin
            check(rx_valid && rx_data == pend_data, "R3 hold", int'(rx_data), int'(pend_data));
        end
        check(!(!rd_n && oe), "R7 contention", int'(oe), 0);
        check(!oe || wr || prev_wr, "R6 bus release", int'(oe), 0);
        if (prev_rd_n && !rd_n) begin
            check(rx_avail_n == 1'b0 && src_ptr < src_total, "R2 read flag", int'(rx_avail_n), 0);
            check(!rx_valid, "R2 read while full", int'(rx_valid), 0);
            if (rr_mode) check(last_op != 1, "R8 alternation", last_op, 2);
            last_op = 1;
        end
        if (!rd_n) rd_run++;
        if (!prev_rd_n && rd_n) begin
            check(rd_run >= 2, "R3 strobe width", rd_run, 2);
            rd_run = 0;
            src_ptr++;
            rx_gap = 1 + int'($urandom % gap_max);
        end
        if (!prev_wr && wr) begin
            check(tx_space_n == 1'b0, "R4 write flag", int'(tx_space_n), 0);
            check(oe, "R5 setup drive", int'(oe), 1);
            if (rr_mode) check(last_op != 2, "R8 alternation", last_op, 1);
            last_op = 2;
        end
        if (prev_wr && !wr) begin
            check(oe, "R5 hold drive", int'(oe), 1);
            check(bus_out == exp_tx(snk_cnt) && snk_cnt < core_tx, "R5 written byte",
                  int'(bus_out), int'(exp_tx(snk_cnt)));
            snk_cnt++;
            tx_gap = 1 + int'($urandom % gap_max);
        end
        rx_avail_n = (src_ptr >= src_total) || (rx_gap > 0);
        tx_space_n = (tx_gap > 0);
        bus_in     = !rd_n ? exp_rx(src_ptr) : 8'($urandom);
        rx_ready   = (int'($urandom % 100) < rx_pct);
        tx_valid   = (core_tx < NBYTES) && (int'($urandom % 100) < tx_pct);
        tx_data    = tx_valid ? exp_tx(core_tx) : 8'($urandom);
        prev_rd_n  = rd_n;
        prev_wr    = wr;
        #1;
        rx_pend   = rx_valid && !rx_ready;
        pend_data = rx_data;
        if (rx_valid && rx_ready) begin
            check(rx_data == exp_rx(core_rx), "R9 receive order", int'(rx_data), int'(exp_rx(core_rx)));
            core_rx++;
        end
        if (tx_valid && tx_ready) core_tx++;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; rx_avail_n = 1'b0; tx_space_n = 1'b0;
        bus_in = 8'h00; rx_ready = 1'b1; tx_valid = 1'b1; tx_data = 8'hA5;
        repeat (5) @(negedge clk);
        check(rd_n && !wr && !oe && !rx_valid && !tx_ready, "R1 reset state",
              {rd_n, wr, oe, rx_valid, tx_ready}, 5'b10000);
        rst_n = 1'b1;

        // directed: both sides saturated, ties every idle cycle
        rr_mode = 1; gap_max = 1; rx_pct = 100; tx_pct = 100;
        for (int i = 0; i < 150 && !timeout; i++) step();
        check(snk_cnt > 5 && core_rx > 5, "R8 both served", snk_cnt, 6);
        rr_mode = 0;

        // random mix
        gap_max = 6; rx_pct = 60; tx_pct = 50;
        for (int i = 0; i < 3000 && !timeout; i++) step();

        // receive back-pressure: FIFO keeps data, core never accepts
        rx_pct = 0; tx_pct = 0;
        for (int i = 0; i < 10 && !timeout; i++) step();
        begin
            int held_ptr;
            held_ptr = src_ptr;
            for (int i = 0; i < 60 && !timeout; i++) step();
            check(src_ptr <= held_ptr + 1, "R2 no read while full", src_ptr, held_ptr + 1);
            check(rx_valid == 1'b1, "R3 byte held", int'(rx_valid), 1);
        end

        // drain
        gap_max = 3; rx_pct = 100; tx_pct = 100;
        while (!timeout && !(core_rx == src_total && snk_cnt == NBYTES)) step();
        repeat (10) step();
        check(core_rx == src_total && src_ptr == src_total, "R9 receive count", core_rx, src_total);
        check(snk_cnt == NBYTES && core_tx == NBYTES, "R9 transmit count", snk_cnt, NBYTES);
        check(rd_n && !wr && !oe, "R6 idle bus", int'(oe), 0);

        if (timeout) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule